// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a one-cycle write request into a complete write cycle on an asynchronous static RAM. The request carries an address and a data word. The block then drives chip-enable, write-enable, the address bus and a tri-state data bus with the correct timing, and holds the memory's output-enable inactive throughout. Timing is set by nanosecond minimums given as integer parameters, together with the system clock period. From these the block works out, at elaboration, how many clock cycles each phase lasts: setup, pulse and recovery.

A write passes through three phases. In the setup phase the address is driven and chip-enable is asserted. In the pulse phase write-enable is low and the data bus is driven. In the recovery phase write-enable is high again, while chip-enable, the address and the data stay in place. The write therefore ends when write-enable rises. Chip-enable stays low for the whole recovery phase, so the shorter recovery minimum for a write-enable-terminated write is the one that applies.

The block reports `busy` while a write is in progress. It gives a one-cycle `done` when the write finishes. A request made while `busy` is high is dropped.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is held and after its release, chip-enable and write-enable are high, the data bus is not driven, `busy` and `done` are low, and output-enable is high.
- R2: When `reqValid` is sampled high while idle, then from the next cycle on chip-enable is low, `busy` is high and the address bus shows the captured `reqAddr`.
- R3: Write-enable falls SETUP_CYC cycles after chip-enable falls, where SETUP_CYC = max(1, ceil(address-setup ns / clock ns)).
- R4: Write-enable stays low for exactly PULSE_CYC cycles. PULSE_CYC is the largest of ceil(pulse ns / T), ceil(data-setup ns / T), ceil(address-valid ns / T) − SETUP_CYC, and 1.
- R5: The data bus is driven from the first write-enable-low cycle through the last recovery cycle, and never before write-enable falls.
- R6: Chip-enable stays low for SETUP_CYC + PULSE_CYC + RECOVER_CYC cycles. RECOVER_CYC is the largest of 1, ceil(recovery ns / T), ceil(hold ns / T), and ceil(cycle-time ns / T) − SETUP_CYC − PULSE_CYC.
- R7: The address stays equal to the captured `reqAddr` while chip-enable is low, and the driven data stays equal to the captured `reqData` while the bus is driven, even if the request inputs change.
- R8: `done` is high for exactly one cycle: the first cycle in which chip-enable is high again. `busy` is low in that same cycle.
- R9: A request made while `busy` is high starts no write. Chip-enable stays high after the current write's `done`.
- R10: The memory output-enable is held high at all times.
- R11: A request made in the cycle where `done` is high is accepted. Chip-enable is low and the new address is shown in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Single-cycle write request |
| reqAddr | input | ADDR_W | Write address, captured with the request |
| reqData | input | DATA_W | Write data, captured with the request |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse when the write completes |
| sramCeN | output | 1 | Memory chip-enable, active low |
| sramWeN | output | 1 | Memory write-enable, active low |
| sramOeN | output | 1 | Memory output-enable, held high |
| sramAddr | output | ADDR_W | Memory address bus |
| sramDataOut | output | DATA_W | Value for the memory data bus |
| sramDataOe | output | 1 | Drive enable for the tri-state data bus |

## Verification
The bench uses a 5 ns clock with the fastest-grade minimums: 0 ns address setup, 55 ns pulse and address-valid, 30 ns data setup, 5 ns recovery, 0 ns hold and 70 ns cycle time. This gives one setup cycle and eleven pulse cycles. The 70 ns cycle-time rule stretches recovery from one cycle to two, so the case where cycle time sets the recovery length is covered. Address width is 15 bits and data width is 8 bits, which lets the bench sweep walking-one addresses and a stride through the full data range. Every write is measured cycle by cycle against counts the bench computes from the same ceiling formulas.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef struct packed {
    logic load;     // capture request (same cycle as acceptance)
    logic ceOn;     // chip-enable asserted
    logic weOn;     // write-enable asserted
    logic driveOn;  // data bus driven
  } wrStrobes_t;

  function automatic int ceilCyc(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 11,
  parameter int RECOVER_CYC = 2,
  parameter int CNT_W       = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output wrStrobes_t strobes,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_RECOVER} wrState_t;

  localparam logic [CNT_W-1:0] SETUP_LD   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD   = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_CYC - 1);

  wrState_t         state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             ceOnQ, weOnQ, driveOnQ, doneQ;
  logic             accept;

  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    cntNext   = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stateNext = ST_SETUP;
        cntNext   = SETUP_LD;
      end
      ST_SETUP: if (cnt == '0) begin
        stateNext = ST_PULSE;
        cntNext   = PULSE_LD;
      end
      ST_PULSE: if (cnt == '0) begin
        stateNext = ST_RECOVER;
        cntNext   = RECOVER_LD;
      end
      ST_RECOVER: if (cnt == '0) begin
        stateNext = ST_IDLE;
        cntNext   = '0;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ceOnQ    <= 1'b0;
      weOnQ    <= 1'b0;
      driveOnQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      ceOnQ    <= (stateNext != ST_IDLE);
      weOnQ    <= (stateNext == ST_PULSE);
      driveOnQ <= (stateNext == ST_PULSE) || (stateNext == ST_RECOVER);
      doneQ    <= (state == ST_RECOVER) && (stateNext == ST_IDLE);
    end
  end

  assign strobes.load    = accept;
  assign strobes.ceOn    = ceOnQ;
  assign strobes.weOn    = weOnQ;
  assign strobes.driveOn = driveOnQ;
  assign busy            = (state != ST_IDLE);
  assign done            = doneQ;

endmodule

// File: rtl/sram_wr_datapath.sv
module sram_wr_datapath
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDataOut,
  output logic              sramDataOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  assign sramAddr    = addrQ;
  assign sramDataOut = dataQ;
  assign sramDataOe  = strobes.driveOn;
  assign sramCeN     = ~strobes.ceOn;
  assign sramWeN     = ~strobes.weOn;
  assign sramOeN     = 1'b1;

endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W          = 15,
  parameter int DATA_W          = 8,
  parameter int CLK_PERIOD_NS   = 5,
  parameter int T_ADDR_SETUP_NS = 0,
  parameter int T_PULSE_NS      = 55,
  parameter int T_ADDR_VALID_NS = 55,
  parameter int T_DATA_SETUP_NS = 30,
  parameter int T_RECOVER_NS    = 5,
  parameter int T_HOLD_NS       = 0,
  parameter int T_CYCLE_NS      = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              sramCeN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDataOut,
  output logic              sramDataOe
);

  localparam int SETUP_CYC = maxOf(1, ceilCyc(T_ADDR_SETUP_NS, CLK_PERIOD_NS));
  localparam int PULSE_CYC = maxOf(1, maxOf(
      maxOf(ceilCyc(T_PULSE_NS, CLK_PERIOD_NS), ceilCyc(T_DATA_SETUP_NS, CLK_PERIOD_NS)),
      ceilCyc(T_ADDR_VALID_NS, CLK_PERIOD_NS) - SETUP_CYC));
  localparam int RECOVER_CYC = maxOf(1, maxOf(
      maxOf(ceilCyc(T_RECOVER_NS, CLK_PERIOD_NS), ceilCyc(T_HOLD_NS, CLK_PERIOD_NS)),
      ceilCyc(T_CYCLE_NS, CLK_PERIOD_NS) - SETUP_CYC - PULSE_CYC));
  localparam int MAX_CYC = maxOf(SETUP_CYC, maxOf(PULSE_CYC, RECOVER_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  wrStrobes_t strobes;

  sram_wr_ctrl #(
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .RECOVER_CYC(RECOVER_CYC),
    .CNT_W      (CNT_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sram_wr_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .sramCeN    (sramCeN),
    .sramWeN    (sramWeN),
    .sramOeN    (sramOeN),
    .sramAddr   (sramAddr),
    .sramDataOut(sramDataOut),
    .sramDataOe (sramDataOe)
  );

endmodule

// File: rtl/sram_write_seq_chk.sv
module sram_write_seq_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              sramCeN,
  input logic              sramWeN,
  input logic              sramOeN,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [DATA_W-1:0] sramDataOut,
  input logic              sramDataOe
);

  a_r10_oe_held_high: assert property (@(posedge clk) disable iff (!rstN)
    sramOeN == 1'b1);

  a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN);

  a_r5_drive_inside_ce: assert property (@(posedge clk) disable iff (!rstN)
    sramDataOe |-> !sramCeN);

  a_r5_drive_at_we_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> sramDataOe);

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (sramDataOe && $past(sramDataOe)) |-> $stable(sramDataOut));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_after_ce_rise: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sramCeN && !busy && $past(!sramCeN)));

  a_r2_busy_tracks_ce: assert property (@(posedge clk) disable iff (!rstN)
    busy == !sramCeN);

endmodule

bind sram_write_seq sram_write_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .sramCeN    (sramCeN),
  .sramWeN    (sramWeN),
  .sramOeN    (sramOeN),
  .sramAddr   (sramAddr),
  .sramDataOut(sramDataOut),
  .sramDataOe (sramDataOe)
);

// File: tb/sram_write_seq_tb_top.sv
`timescale 1ns/1ps
module sram_write_seq_tb_top;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int PER = 5;
  localparam int NS_AS = 0, NS_WP = 55, NS_AW = 55, NS_DW = 30;
  localparam int NS_WR = 5, NS_DH = 0, NS_WC = 70;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ES = mx(1, cdiv(NS_AS));
  localparam int EP = mx(1, mx(mx(cdiv(NS_WP), cdiv(NS_DW)), cdiv(NS_AW) - ES));
  localparam int ER = mx(1, mx(mx(cdiv(NS_WR), cdiv(NS_DH)), cdiv(NS_WC) - ES - EP));

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          busy, done, sramCeN, sramWeN, sramOeN, sramDataOe;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramDataOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sram_write_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER),
    .T_ADDR_SETUP_NS(NS_AS), .T_PULSE_NS(NS_WP), .T_ADDR_VALID_NS(NS_AW),
    .T_DATA_SETUP_NS(NS_DW), .T_RECOVER_NS(NS_WR), .T_HOLD_NS(NS_DH),
    .T_CYCLE_NS(NS_WC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .busy(busy), .done(done), .sramCeN(sramCeN),
    .sramWeN(sramWeN), .sramOeN(sramOeN), .sramAddr(sramAddr),
    .sramDataOut(sramDataOut), .sramDataOe(sramDataOe)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // One write; samples every negedge after acceptance.
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int ceLow = 0, weLow = 0, oeCnt = 0, firstCe = 0, firstWe = 0, firstOe = 0;
    int doneAt = 0, doneCnt = 0, addrBad = 0, dataBad = 0, oeNBad = 0, lateCe = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;
    for (int k = 1; k <= 40; k++) begin
      if (!sramCeN) begin
        ceLow++;
        if (firstCe == 0) firstCe = k;
        if (sramAddr != a) addrBad++;
        if (doneAt != 0) lateCe++;
      end
      if (!sramWeN) begin
        weLow++;
        if (firstWe == 0) firstWe = k;
      end
      if (sramDataOe) begin
        oeCnt++;
        if (firstOe == 0) firstOe = k;
        if (sramDataOut != d) dataBad++;
      end
      if (!sramOeN) oeNBad++;
      if (done) begin
        doneCnt++;
        if (doneAt == 0) doneAt = k;
      end
      if (poke && k == 4) begin
        reqValid = 1'b1; reqAddr = a ^ 15'h5555; reqData = ~d;
      end
      if (poke && k == 5) reqValid = 1'b0;
      @(negedge clk);
    end
    chk("R2 first CE-low sample", firstCe, 1);
    chk("R3 WE fall offset", firstWe, 1 + ES);
    chk("R4 WE low cycles", weLow, EP);
    chk("R5 drive starts with WE", firstOe, firstWe);
    chk("R5 drive cycles", oeCnt, EP + ER);
    chk("R6 CE low cycles", ceLow, ES + EP + ER);
    chk("R7 address mismatches", addrBad, 0);
    chk("R7 data mismatches", dataBad, 0);
    chk("R8 done sample", doneAt, ES + EP + ER + 1);
    chk("R8 done count", doneCnt, 1);
    chk("R10 OE low samples", oeNBad, 0);
    if (poke) chk("R9 CE low after done", lateCe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 CE in reset", sramCeN, 1);
    chk("R1 WE in reset", sramWeN, 1);
    chk("R1 drive in reset", sramDataOe, 0);
    chk("R1 busy in reset", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 CE after reset", sramCeN, 1);
    chk("R1 done after reset", done, 0);
    chk("R1 OE after reset", sramOeN, 1);

    // Sweep: walking-one addresses with strided data
    for (int i = 0; i < AW; i++)
      doWrite(AW'(1) << i, DW'(i * 17 + 3), 1'b0);
    for (int j = 0; j < 256; j += 51)
      doWrite(AW'(j * 97), DW'(j), 1'b1);   // R9: request while busy
    doWrite('1, '1, 1'b1);
    doWrite('0, '0, 1'b0);

    // R11: back-to-back request in the done cycle
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 15'h1234; reqData = 8'hA5;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    chk("R8 done seen before chained request", done, 1);
    reqValid = 1'b1; reqAddr = 15'h4321; reqData = 8'h5A;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R11 CE low after chained request", sramCeN, 0);
    chk("R11 chained address", sramAddr, 15'h4321);
    chk("R11 busy after chained request", busy, 1);
    for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    @(negedge clk);
    chk("R8 idle after chained write", busy, 0);

    finishRun();
  end

endmodule